// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Controller

This block sits between the peripherals that share one level-sensitive request line and the control unit of a multicycle processor. When the control unit signals that an instruction has just completed, and interrupts are enabled, the controller raises an acknowledge line. It waits for the requesting device to withdraw its request and drive a vector index, and it captures that index. It reads the handler address from a 16-entry internal vector table and then asks the processor to load that address into its program counter. In the same cycle it copies the interrupted PC into a dedicated return register.

The controller also owns the global interrupt-enable flag. Separate enable and disable commands set and clear the flag, and entry into the acknowledge sequence clears it, so a second request cannot overwrite the return register before the handler has preserved it. A return command reloads the PC from the return register and turns interrupts back on. If no device answers the acknowledge within a fixed window, the sequence is abandoned.

States are IDLE, ACK, CAPTURE, LOOKUP, JUMP and RETURN. The transitions are as follows:
- IDLE→ACK on take: boundary, request and enable all high.
- IDLE→RETURN on a return command.
- ACK→CAPTURE when the request drops.
- ACK→IDLE on expire, when the wait window runs out.
- CAPTURE→LOOKUP, LOOKUP→JUMP, JUMP→IDLE and RETURN→IDLE always.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, irq_ack, pc_load, busy and irq_en are 0, and saved_pc is 0.
- R2: A take happens only in IDLE with at_boundary, irq_req and irq_en all high on a clock edge. irq_ack and busy are 1 in the next cycle. Otherwise irq_ack stays 0.
- R3: irq_en is 0 in the first cycle that irq_ack is 1. Entry clears the flag.
- R4: irq_ack stays 1 while irq_req is held high (up to the timeout), and for one more cycle after the edge at which irq_req is seen low. The vector is taken from dbus_vec in that extra cycle.
- R5: pc_load is high for exactly one cycle. It occurs in the third cycle after the edge at which irq_req is seen low. pc_next then equals the table entry indexed by the captured vector.
- R6: After the pc_load cycle of an interrupt entry, saved_pc holds the cur_pc value presented during that cycle.
- R7: If irq_req is still high after irq_ack has been 1 for TIMEOUT (8) cycles, irq_ack drops, busy drops and irq_en returns to 1.
- R8: With tbl_we high on a clock edge, entry tbl_idx (0 to 15) of the vector table takes tbl_wdata.
- R9: cmd_ei sets irq_en and cmd_di clears it at the next edge. When both are high, cmd_di wins.
- R10: cmd_rti in IDLE gives, in the next cycle, a one-cycle pc_load with pc_next equal to saved_pc, and irq_en is 1 in that cycle. A return command wins over a simultaneous take, so irq_ack stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| at_boundary | input | 1 | Control unit is at an instruction boundary |
| irq_req | input | 1 | Shared level interrupt request from devices |
| dbus_vec | input | VEC_W | Low bits of the data bus carrying the device's vector |
| cmd_ei | input | 1 | Enable-interrupts command |
| cmd_di | input | 1 | Disable-interrupts command |
| cmd_rti | input | 1 | Return-from-interrupt command |
| cur_pc | input | ADDR_W | Processor's current PC |
| tbl_we | input | 1 | Vector table write strobe |
| tbl_idx | input | VEC_W | Vector table write index |
| tbl_wdata | input | ADDR_W | Handler address to write |
| irq_ack | output | 1 | Acknowledge to devices |
| busy | output | 1 | Sequence in progress; control unit holds |
| irq_en | output | 1 | Global interrupt-enable flag |
| pc_load | output | 1 | One-cycle strobe to load pc_next into the PC |
| pc_next | output | ADDR_W | Handler address or return address |
| saved_pc | output | ADDR_W | Return register |

## Verification
The assertions assume that devices follow the handshake: they drop irq_req only while irq_ack is high, and they hold the vector on dbus_vec until irq_ack falls. They also assume that the control unit holds cur_pc steady while busy is high. The stimulus models one device that waits a random 0 to 7 cycles after seeing the acknowledge before it withdraws and drives a random vector. It drives cur_pc before the take and leaves it alone until the sequence ends. A separate directed case never answers the acknowledge, so the expire path is covered.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ACK     = 3'd1,
        ST_CAPTURE = 3'd2,
        ST_LOOKUP  = 3'd3,
        ST_JUMP    = 3'd4,
        ST_RETURN  = 3'd5
    } irq_state_e;
endpackage

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  ridx,
    output logic [ADDR_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ADDR_W-1:0] entry_q [DEPTH];

    // one register per entry, written by index
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                entry_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= entry_q[ridx];
        end
    end
endmodule

// File: rtl/irq_enable_flag.sv
module irq_enable_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic force_clr,
    input  logic force_set,
    input  logic clr_cmd,
    input  logic set_cmd,
    output logic en
);
    // priority: entry clear, then restore, then disable, then enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else if (force_clr) begin
            en <= 1'b0;
        end else if (force_set) begin
            en <= 1'b1;
        end else if (clr_cmd) begin
            en <= 1'b0;
        end else if (set_cmd) begin
            en <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_ack_pkg::*;
#(
    parameter int VEC_W   = 4,
    parameter int TIMEOUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             at_boundary,
    input  logic             irq_req,
    input  logic             irq_en,
    input  logic             cmd_rti,
    input  logic [VEC_W-1:0] dbus_vec,
    output logic             irq_ack,
    output logic             busy,
    output logic             take,
    output logic             resume,
    output logic             expire,
    output logic             lookup,
    output logic             jump,
    output logic             ret,
    output logic [VEC_W-1:0] vec
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

    irq_state_e       state_q, state_d;
    logic [CNT_W-1:0] wait_cnt;

    assign take   = (state_q == ST_IDLE) && !cmd_rti && at_boundary && irq_req && irq_en;
    assign resume = (state_q == ST_IDLE) && cmd_rti;
    assign expire = (state_q == ST_ACK) && irq_req && (wait_cnt == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (resume)    state_d = ST_RETURN;
                else if (take) state_d = ST_ACK;
            end
            ST_ACK: begin
                if (!irq_req)    state_d = ST_CAPTURE;
                else if (expire) state_d = ST_IDLE;
            end
            ST_CAPTURE: state_d = ST_LOOKUP;
            ST_LOOKUP:  state_d = ST_JUMP;
            ST_JUMP:    state_d = ST_IDLE;
            ST_RETURN:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            wait_cnt <= '0;
            vec      <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_ACK) wait_cnt <= '0;
            else                   wait_cnt <= wait_cnt + 1'b1;
            if (state_q == ST_CAPTURE) vec <= dbus_vec;
        end
    end

    always_comb begin
        irq_ack = 1'b0;
        busy    = 1'b1;
        lookup  = 1'b0;
        jump    = 1'b0;
        ret     = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy    = 1'b0;
            ST_ACK:     irq_ack = 1'b1;
            ST_CAPTURE: irq_ack = 1'b1;
            ST_LOOKUP:  lookup  = 1'b1;
            ST_JUMP:    jump    = 1'b1;
            ST_RETURN:  ret     = 1'b1;
            default:    busy    = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
    parameter int VEC_W   = 4,
    parameter int ADDR_W  = 16,
    parameter int TIMEOUT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_boundary,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  dbus_vec,
    input  logic              cmd_ei,
    input  logic              cmd_di,
    input  logic              cmd_rti,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              tbl_we,
    input  logic [VEC_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_wdata,
    output logic              irq_ack,
    output logic              busy,
    output logic              irq_en,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_next,
    output logic [ADDR_W-1:0] saved_pc
);
    logic             take, resume, expire, lookup, jump, ret;
    logic [VEC_W-1:0] vec;
    logic [ADDR_W-1:0] handler;

    irq_ack_fsm #(.VEC_W(VEC_W), .TIMEOUT(TIMEOUT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .irq_req(irq_req),
        .irq_en(irq_en), .cmd_rti(cmd_rti), .dbus_vec(dbus_vec),
        .irq_ack(irq_ack), .busy(busy), .take(take), .resume(resume),
        .expire(expire), .lookup(lookup), .jump(jump), .ret(ret), .vec(vec)
    );

    irq_enable_flag u_en (
        .clk(clk), .rst_n(rst_n), .force_clr(take), .force_set(resume | expire),
        .clr_cmd(cmd_di), .set_cmd(cmd_ei), .en(irq_en)
    );

    irq_vec_table #(.IDX_W(VEC_W), .ADDR_W(ADDR_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx), .wdata(tbl_wdata),
        .rd_en(lookup), .ridx(vec), .rdata(handler)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)    saved_pc <= '0;
        else if (jump) saved_pc <= cur_pc;
    end

    assign pc_load = jump | ret;
    assign pc_next = jump ? handler : saved_pc;
endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk #(
    parameter int ADDR_W  = 16,
    parameter int TIMEOUT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              at_boundary,
    input logic              irq_req,
    input logic              irq_ack,
    input logic              irq_en,
    input logic              pc_load,
    input logic [ADDR_W-1:0] cur_pc,
    input logic [ADDR_W-1:0] saved_pc
);
    localparam int RUN_MAX = TIMEOUT + 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 2);

    logic [RUN_W-1:0] ack_run;

    always_ff @(posedge clk) begin
        if (!rst_n)                             ack_run <= '0;
        else if (!irq_ack)                      ack_run <= '0;
        else if (ack_run <= RUN_W'(RUN_MAX))    ack_run <= ack_run + 1'b1;
    end

    AST_TAKE_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ack) |-> $past(at_boundary && irq_req && irq_en)); // R2
    AST_ENTRY_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ack) |-> !irq_en); // R3
    AST_ACK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_run <= RUN_W'(RUN_MAX)); // R7
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load); // R5
    AST_LOAD_NOT_DURING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_load && irq_ack)); // R5
    AST_SAVED_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pc_load) && $past(irq_ack, 3)) |-> (saved_pc == $past(cur_pc))); // R6
    AST_RETURN_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !$past(irq_ack, 2) && !$past(irq_ack)) |-> irq_en); // R10
endmodule

bind irq_ack_ctrl irq_ack_chk #(.ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .irq_req(irq_req),
    .irq_ack(irq_ack), .irq_en(irq_en), .pc_load(pc_load), .cur_pc(cur_pc),
    .saved_pc(saved_pc)
);

// File: tb/tb_irq_ack_ctrl.sv
module tb_irq_ack_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int VEC_W   = 4;
    localparam int ADDR_W  = 16;
    localparam int TIMEOUT = 8;
    localparam int DEPTH   = 1 << VEC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic at_boundary = 1'b0, irq_req = 1'b0, cmd_ei = 1'b0, cmd_di = 1'b0, cmd_rti = 1'b0;
    logic tbl_we = 1'b0;
    logic [VEC_W-1:0] dbus_vec = '0, tbl_idx = '0;
    logic [ADDR_W-1:0] cur_pc = '0, tbl_wdata = '0;
    logic irq_ack, busy, irq_en, pc_load;
    logic [ADDR_W-1:0] pc_next, saved_pc;

    int n_chk = 0;
    int n_bad = 0;
    logic [ADDR_W-1:0] model_tbl [DEPTH];
    logic [ADDR_W-1:0] model_saved = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ack_ctrl #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) dut (
        .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .irq_req(irq_req),
        .dbus_vec(dbus_vec), .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_rti(cmd_rti),
        .cur_pc(cur_pc), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
        .irq_ack(irq_ack), .busy(busy), .irq_en(irq_en), .pc_load(pc_load),
        .pc_next(pc_next), .saved_pc(saved_pc)
    );

    function automatic logic [ADDR_W-1:0] exp_handler(input logic [VEC_W-1:0] v);
        return model_tbl[v];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_tbl(input logic [VEC_W-1:0] idx, input logic [ADDR_W-1:0] d);
        tbl_we = 1'b1; tbl_idx = idx; tbl_wdata = d;
        tick();
        tbl_we = 1'b0;
        model_tbl[idx] = d;
    endtask

    task automatic set_en(input bit ei, input bit di);
        cmd_ei = ei; cmd_di = di;
        tick();
        cmd_ei = 1'b0; cmd_di = 1'b0;
    endtask

    // one full interrupt entry with a device answering after dly cycles
    task automatic serve(input logic [VEC_W-1:0] v, input int dly, input logic [ADDR_W-1:0] pc);
        int n;
        set_en(1'b1, 1'b0);
        cur_pc = pc; irq_req = 1'b1; at_boundary = 1'b1;
        tick();
        at_boundary = 1'b0;
        check(irq_ack == 1'b1 && busy == 1'b1, "R2 ack after take", {30'd0, irq_ack, busy}, 32'd3);
        check(irq_en == 1'b0, "R3 enable cleared on entry", 32'(irq_en), 32'd0);
        for (int i = 0; i < dly; i++) begin
            tick();
            check(irq_ack == 1'b1, "R4 ack held while request high", 32'(irq_ack), 32'd1);
        end
        irq_req = 1'b0; dbus_vec = v;
        tick();
        check(irq_ack == 1'b1, "R4 ack in capture cycle", 32'(irq_ack), 32'd1);
        n = 1;
        while (!pc_load && n < 10) begin
            tick();
            n++;
        end
        check(n == 3, "R5 pc_load latency", 32'(n), 32'd3);
        check(pc_next == exp_handler(v), "R5 handler address", 32'(pc_next), 32'(exp_handler(v)));
        cur_pc = cur_pc; // held until the sequence ends
        tick();
        dbus_vec = '0;
        model_saved = pc;
        check(pc_load == 1'b0, "R5 pc_load one cycle", 32'(pc_load), 32'd0);
        check(saved_pc == model_saved, "R6 saved pc", 32'(saved_pc), 32'(model_saved));
    endtask

    task automatic do_rti();
        cmd_rti = 1'b1;
        tick();
        cmd_rti = 1'b0;
        check(pc_load == 1'b1 && pc_next == model_saved, "R10 return target",
              32'(pc_next), 32'(model_saved));
        check(irq_en == 1'b1, "R10 return enables", 32'(irq_en), 32'd1);
        tick();
        check(pc_load == 1'b0, "R10 return strobe one cycle", 32'(pc_load), 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int n;
        void'($urandom(32'd7301));
        for (int i = 0; i < DEPTH; i++) model_tbl[i] = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check(irq_ack == 0 && pc_load == 0 && busy == 0 && irq_en == 0, "R1 reset outputs",
              {28'd0, irq_ack, pc_load, busy, irq_en}, 32'd0);
        check(saved_pc == '0, "R1 reset saved pc", 32'(saved_pc), 32'd0);

        // R8 table fill with random handlers
        for (int i = 0; i < DEPTH; i++) write_tbl(VEC_W'(i), ADDR_W'($urandom));

        // R2: disabled -> no take
        irq_req = 1'b1; at_boundary = 1'b1;
        repeat (4) begin
            tick();
            check(irq_ack == 1'b0, "R2 no take while disabled", 32'(irq_ack), 32'd0);
        end
        // R2: enabled but no boundary -> no take
        at_boundary = 1'b0;
        set_en(1'b1, 1'b0);
        repeat (3) begin
            tick();
            check(irq_ack == 1'b0, "R2 no take off boundary", 32'(irq_ack), 32'd0);
        end
        irq_req = 1'b0;

        // R9: both commands -> disable wins
        set_en(1'b1, 1'b1);
        check(irq_en == 1'b0, "R9 disable wins", 32'(irq_en), 32'd0);
        set_en(1'b1, 1'b0);
        check(irq_en == 1'b1, "R9 enable sets", 32'(irq_en), 32'd1);
        set_en(1'b0, 1'b1);
        check(irq_en == 1'b0, "R9 disable clears", 32'(irq_en), 32'd0);

        // directed corners: fastest and slowest device answers, first and last vector
        serve(VEC_W'(0), 0, 16'h1234);
        do_rti();
        serve(VEC_W'(DEPTH-1), TIMEOUT-1, 16'hBEEF);
        do_rti();

        // R7: device never answers
        set_en(1'b1, 1'b0);
        irq_req = 1'b1; at_boundary = 1'b1;
        tick();
        at_boundary = 1'b0;
        n = 0;
        while (irq_ack && n < 20) begin
            n++;
            tick();
        end
        check(n == TIMEOUT, "R7 ack window length", 32'(n), 32'(TIMEOUT));
        check(busy == 1'b0 && irq_en == 1'b1, "R7 idle and re-enabled after timeout",
              {30'd0, busy, irq_en}, 32'd1);
        irq_req = 1'b0;
        tick();

        // R10: return wins over simultaneous take
        irq_req = 1'b1; at_boundary = 1'b1; cmd_rti = 1'b1;
        tick();
        cmd_rti = 1'b0; at_boundary = 1'b0; irq_req = 1'b0;
        check(pc_load == 1'b1 && irq_ack == 1'b0, "R10 return beats take",
              {30'd0, pc_load, irq_ack}, 32'd2);
        tick();

        // R8: rewrite one entry and use it
        write_tbl(VEC_W'(5), 16'hA5A5);
        serve(VEC_W'(5), 2, 16'h0042);
        do_rti();

        // random sequences
        for (int k = 0; k < 40; k++) begin
            if (($urandom % 4) == 0) write_tbl(VEC_W'($urandom), ADDR_W'($urandom));
            serve(VEC_W'($urandom), int'($urandom % TIMEOUT), ADDR_W'($urandom));
            if (($urandom % 2) == 0) do_rti();
            repeat (int'($urandom % 3)) tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule